// File: doc/BRIEF.md
# Enable-Driven Channel Sample Packer

The packer gathers 16-bit samples from four receive channels into one 64-bit word for a downstream stream sink. A software-set enable mask decides which channels take part. The word is always fully used: one enabled channel contributes four samples, two enabled channels contribute two each, and four enabled channels contribute one each. Slot numbering inside the word follows time first and channel rank second: slot = sample_index * enabled_count + rank. Rank is the position of the channel among the enabled channels, counted from the lowest index. Older samples therefore land in lower bits, and the newest sample is in bits 63:48.

Each channel has its own valid strobe and its own fill count, so channels whose samples arrive at different times still pack correctly. The finished word sits in a single output register with a valid/ready handshake. If the next word completes while that register is still stalled, the new word is discarded and the overflow flag pulses.

A change of the enable mask throws away the partly filled word, so no word ever mixes two channel configurations. A mask with a channel count other than one, two or four is treated as all four channels.

Top module: `channel_packer`

## Requirements
- R1: After reset, out_valid_o and ovf_o are low.
- R2: With all four channels enabled, each word holds one sample per channel, channel k in bits [16k+15:16k].
- R3: With one channel enabled, four consecutive samples of that channel form a word: the oldest is in bits 15:0 and the newest in bits 63:48.
- R4: Samples of disabled channels are ignored whatever their valid, and an all-zero mask never produces a word.
- R5: With two channels enabled (lower index A, higher index B), the word is {B1, A1, B0, A0} from MSB to LSB, where 0 marks the older sample.
- R6: Each channel counts its own samples. A word is presented on the cycle after the last required sample is accepted, however far apart the channels' valids are.
- R7: A sample that arrives for a channel which already holds its share of the current word is discarded.
- R8: A mask with three bits set is treated as all four channels enabled.
- R9: In a cycle where ch_en_i differs from its value in the previous cycle, the partial word and that cycle's samples are discarded, and no word is completed.
- R10: A word that completes while out_valid_o is high and out_ready_i is low is discarded, and ovf_o is high for the following cycle.
- R11: out_valid_o and out_data_o hold while out_ready_i is low. With out_ready_i high, a new word may replace the old one on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ch_en_i | input | NUM_CH | Per-channel enable mask (software level) |
| ch_valid_i | input | NUM_CH | Per-channel sample strobe |
| ch_data_i | input | NUM_CH*SAMP_W | Channel samples, channel k at [SAMP_W*k +: SAMP_W] |
| out_ready_i | input | 1 | Downstream accepts the word |
| out_valid_o | output | 1 | Packed word present |
| out_data_o | output | NUM_CH*SAMP_W | Packed word |
| ovf_o | output | 1 | One-cycle pulse when a finished word was dropped |

## Verification
The bench builds the block with its default parameters: four channels of 16 bits, giving a 64-bit word. With these values every packing density is reachable: one, two and four channels, plus the three-channel mask that folds to four. The four-lane width is also small enough to drive skewed valids, excess samples on a full lane and mask changes in the middle of a word, with hand-computed expected words. Stalling out_ready_i across two completions exercises the drop-and-pulse path together with the hold of the stalled word.

// File: rtl/cpk_pkg.sv
package cpk_pkg;
  localparam int CPK_NUM_CH = 4;
  localparam int CPK_SAMP_W = 16;

  function automatic int cpk_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/cpk_lane_map.sv
module cpk_lane_map
  import cpk_pkg::*;
#(
  parameter int NUM_CH = CPK_NUM_CH
) (
  input  logic [NUM_CH-1:0]            en_i,
  output logic [NUM_CH-1:0]            eff_o,
  output logic [cpk_w(cpk_w(NUM_CH)+1)-1:0] lg_o,
  output logic [cpk_w(NUM_CH+1)-1:0]   depth_o,
  output logic [cpk_w(NUM_CH)-1:0]     rank_o [NUM_CH]
);
  localparam int LG_MAX = $clog2(NUM_CH);
  localparam int LG_W   = cpk_w(LG_MAX + 1);
  localparam int CNT_W  = cpk_w(NUM_CH + 1);
  localparam int RK_W   = cpk_w(NUM_CH);

  logic [CNT_W-1:0] pop;
  logic             pow2;

  always_comb begin
    pop  = CNT_W'($countones(en_i));
    pow2 = 1'b0;
    lg_o = LG_W'(LG_MAX);
    for (int j = 0; j <= LG_MAX; j++) begin
      if (pop == CNT_W'(1 << j)) begin
        pow2 = 1'b1;
        lg_o = LG_W'(j);
      end
    end
    if (pop == '0)  eff_o = '0;
    else if (pow2)  eff_o = en_i;
    else            eff_o = '1;   // odd counts fold to full width
    depth_o = CNT_W'(NUM_CH >> lg_o);
  end

  always_comb begin
    int acc;
    acc = 0;
    for (int k = 0; k < NUM_CH; k++) begin
      rank_o[k] = RK_W'(acc);
      acc += int'(eff_o[k]);
    end
  end
endmodule

// File: rtl/cpk_lane_fill.sv
module cpk_lane_fill
  import cpk_pkg::*;
#(
  parameter int NUM_CH = CPK_NUM_CH
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_i,
  input  logic                         part_i,
  input  logic                         valid_i,
  input  logic [cpk_w(NUM_CH+1)-1:0]   depth_i,
  output logic                         accept_o,
  output logic                         last_o,
  output logic [cpk_w(NUM_CH+1)-1:0]   cnt_o
);
  localparam int CNT_W = cpk_w(NUM_CH + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             full;

  assign full     = cnt_q >= depth_i;
  assign accept_o = part_i & valid_i & ~full;
  // lane is satisfied when idle, already full, or filling its last slot now
  assign last_o   = ~part_i | full | (accept_o & ((cnt_q + CNT_W'(1)) == depth_i));
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (accept_o) cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/cpk_word_asm.sv
module cpk_word_asm
  import cpk_pkg::*;
#(
  parameter int NUM_CH = CPK_NUM_CH,
  parameter int SAMP_W = CPK_SAMP_W
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_CH-1:0]                 accept_i,
  input  logic [cpk_w(NUM_CH+1)-1:0]        cnt_i [NUM_CH],
  input  logic [cpk_w(NUM_CH)-1:0]          rank_i [NUM_CH],
  input  logic [cpk_w(cpk_w(NUM_CH)+1)-1:0] lg_i,
  input  logic [NUM_CH*SAMP_W-1:0]          data_i,
  output logic [NUM_CH*SAMP_W-1:0]          word_o
);
  localparam int WORD_W = NUM_CH * SAMP_W;

  logic [WORD_W-1:0] buf_q;

  always_comb begin
    word_o = buf_q;
    for (int k = 0; k < NUM_CH; k++) begin
      int slot;
      slot = (int'(cnt_i[k]) << lg_i) | int'(rank_i[k]);
      if (accept_i[k] && slot < NUM_CH)
        word_o[slot*SAMP_W +: SAMP_W] = data_i[k*SAMP_W +: SAMP_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) buf_q <= '0;
    else         buf_q <= word_o;
  end
endmodule

// File: rtl/cpk_out_stage.sv
module cpk_out_stage
  import cpk_pkg::*;
#(
  parameter int WORD_W = CPK_NUM_CH * CPK_SAMP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o,
  output logic              ovf_o
);
  logic free;
  assign free = ~valid_o | ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      ovf_o   <= 1'b0;
    end else begin
      ovf_o <= load_i & ~free;
      if (load_i && free) begin
        valid_o <= 1'b1;
        data_o  <= word_i;
      end else if (ready_i) begin
        valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/channel_packer.sv
module channel_packer
  import cpk_pkg::*;
#(
  parameter int NUM_CH = CPK_NUM_CH,
  parameter int SAMP_W = CPK_SAMP_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_CH-1:0]        ch_en_i,
  input  logic [NUM_CH-1:0]        ch_valid_i,
  input  logic [NUM_CH*SAMP_W-1:0] ch_data_i,
  input  logic                     out_ready_i,
  output logic                     out_valid_o,
  output logic [NUM_CH*SAMP_W-1:0] out_data_o,
  output logic                     ovf_o
);
  localparam int WORD_W = NUM_CH * SAMP_W;
  localparam int LG_W   = cpk_w(cpk_w(NUM_CH) + 1);
  localparam int CNT_W  = cpk_w(NUM_CH + 1);
  localparam int RK_W   = cpk_w(NUM_CH);

  logic [NUM_CH-1:0] en_q;
  logic              mask_chg;
  logic [NUM_CH-1:0] eff;
  logic [LG_W-1:0]   lg;
  logic [CNT_W-1:0]  depth;
  logic [RK_W-1:0]   rank [NUM_CH];
  logic [CNT_W-1:0]  cnt  [NUM_CH];
  logic [NUM_CH-1:0] acc;
  logic [NUM_CH-1:0] last;
  logic              word_done;
  logic [WORD_W-1:0] word_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= ch_en_i;
  end

  assign mask_chg  = ch_en_i != en_q;
  assign word_done = (&last) & (|eff) & ~mask_chg;

  cpk_lane_map #(.NUM_CH(NUM_CH)) u_map (
    .en_i    (ch_en_i),
    .eff_o   (eff),
    .lg_o    (lg),
    .depth_o (depth),
    .rank_o  (rank)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_lane
    cpk_lane_fill #(.NUM_CH(NUM_CH)) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (mask_chg | word_done),
      .part_i   (eff[k] & ~mask_chg),
      .valid_i  (ch_valid_i[k]),
      .depth_i  (depth),
      .accept_o (acc[k]),
      .last_o   (last[k]),
      .cnt_o    (cnt[k])
    );
  end

  cpk_word_asm #(.NUM_CH(NUM_CH), .SAMP_W(SAMP_W)) u_asm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (acc),
    .cnt_i    (cnt),
    .rank_i   (rank),
    .lg_i     (lg),
    .data_i   (ch_data_i),
    .word_o   (word_nxt)
  );

  cpk_out_stage #(.WORD_W(WORD_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (word_done),
    .word_i  (word_nxt),
    .ready_i (out_ready_i),
    .valid_o (out_valid_o),
    .data_o  (out_data_o),
    .ovf_o   (ovf_o)
  );
endmodule

// File: rtl/channel_packer_chk.sv
module channel_packer_chk #(
  parameter int NUM_CH = 4,
  parameter int SAMP_W = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NUM_CH-1:0]        ch_en_i,
  input logic                     out_ready_i,
  input logic                     out_valid_o,
  input logic [NUM_CH*SAMP_W-1:0] out_data_o,
  input logic                     ovf_o
);
  AST_OVF_NEEDS_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> ($past(out_valid_o) && !$past(out_ready_i))); // R10

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o))); // R11

  AST_NO_WORD_WITHOUT_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> ($past(ch_en_i) != '0)); // R4

  AST_NO_WORD_ON_MASK_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> ($past(ch_en_i) == $past(ch_en_i, 2))); // R9
endmodule

bind channel_packer channel_packer_chk #(.NUM_CH(NUM_CH), .SAMP_W(SAMP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ch_en_i     (ch_en_i),
  .out_ready_i (out_ready_i),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o),
  .ovf_o       (ovf_o)
);

// File: tb/channel_packer_test.sv
`timescale 1ns/1ps
module channel_packer_test;
  localparam int NC = 4;
  localparam int SW = 16;
  localparam int WW = NC * SW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NC-1:0] ch_en_i = '0;
  logic [NC-1:0] ch_valid_i = '0;
  logic [WW-1:0] ch_data_i = '0;
  logic          out_ready_i = 1'b1;
  logic          out_valid_o;
  logic [WW-1:0] out_data_o;
  logic          ovf_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [WW-1:0] exp_q [$];
  string         tag_q [$];

  always #2.5 clk_i = ~clk_i;

  channel_packer uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_word(input logic [WW-1:0] w, input string tag);
    exp_q.push_back(w);
    tag_q.push_back(tag);
  endtask

  // monitor: pops one expected word per handshake
  always @(negedge clk_i) begin
    if (rst_ni && out_valid_o && out_ready_i) begin
      if (exp_q.size() == 0) chk(1'b0, "R11 unexpected word", out_data_o, '0);
      else begin
        logic [WW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(out_data_o == e, t, out_data_o, e);
      end
    end
  end

  task automatic beat(input logic [NC-1:0] v, input logic [SW-1:0] d0, d1, d2, d3);
    ch_valid_i = v;
    ch_data_i  = {d3, d2, d1, d0};
    @(posedge clk_i); #1;
    ch_valid_i = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic set_mask(input logic [NC-1:0] m);
    ch_en_i = m;
    idle(2);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      chk(1'b0, "watchdog", '0, '1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk(out_valid_o == 1'b0, "R1 valid in reset", WW'(out_valid_o), '0);
    rst_ni = 1'b1;
    idle(2);
    chk(out_valid_o == 1'b0, "R1 valid after reset", WW'(out_valid_o), '0);
    chk(ovf_o == 1'b0, "R1 ovf after reset", WW'(ovf_o), '0);

    // R4: empty mask
    set_mask(4'b0000);
    beat(4'b1111, 16'h1, 16'h2, 16'h3, 16'h4);
    beat(4'b1111, 16'h5, 16'h6, 16'h7, 16'h8);
    idle(1);
    chk(out_valid_o == 1'b0, "R4 empty mask", WW'(out_valid_o), '0);

    // R2: four channels, back to back
    set_mask(4'b1111);
    expect_word({16'hA003, 16'hA002, 16'hA001, 16'hA000}, "R2 word0");
    beat(4'b1111, 16'hA000, 16'hA001, 16'hA002, 16'hA003);
    expect_word({16'hB003, 16'hB002, 16'hB001, 16'hB000}, "R2 word1");
    beat(4'b1111, 16'hB000, 16'hB001, 16'hB002, 16'hB003);
    idle(2);

    // R3 + R4: single channel 0, others strobing junk
    set_mask(4'b0001);
    expect_word({16'hC003, 16'hC002, 16'hC001, 16'hC000}, "R3 ch0 order");
    beat(4'b1111, 16'hC000, 16'hDEAD, 16'hDEAD, 16'hDEAD);
    beat(4'b1111, 16'hC001, 16'hDEAD, 16'hDEAD, 16'hDEAD);
    beat(4'b1111, 16'hC002, 16'hDEAD, 16'hDEAD, 16'hDEAD);
    beat(4'b1111, 16'hC003, 16'hDEAD, 16'hDEAD, 16'hDEAD);
    idle(2);

    // R3: single channel 2
    set_mask(4'b0100);
    expect_word({16'h2203, 16'h2202, 16'h2201, 16'h2200}, "R3 ch2 order");
    for (int i = 0; i < 4; i++) beat(4'b0100, 16'h0, 16'h0, 16'h2200 + 16'(i), 16'h0);
    idle(2);

    // R5: two channels 1 and 2
    set_mask(4'b0110);
    expect_word({16'hB201, 16'hA101, 16'hB200, 16'hA100}, "R5 pair layout");
    beat(4'b0110, 16'h0, 16'hA100, 16'hB200, 16'h0);
    beat(4'b0110, 16'h0, 16'hA101, 16'hB201, 16'h0);
    idle(2);

    // R6: skewed valids on channels 1 and 3
    set_mask(4'b1010);
    expect_word({16'h3311, 16'h1111, 16'h3310, 16'h1110}, "R6 skewed lanes");
    beat(4'b0010, 16'h0, 16'h1110, 16'h0, 16'h0);
    beat(4'b0010, 16'h0, 16'h1111, 16'h0, 16'h0);
    idle(1);
    beat(4'b1000, 16'h0, 16'h0, 16'h0, 16'h3310);
    idle(1);
    chk(out_valid_o == 1'b0, "R6 early word", WW'(out_valid_o), '0);
    beat(4'b1000, 16'h0, 16'h0, 16'h0, 16'h3311);
    chk(out_valid_o == 1'b1, "R6 word after last sample", WW'(out_valid_o), WW'(1));
    idle(2);

    // R7: excess samples on a full lane dropped
    set_mask(4'b0011);
    expect_word({16'h5B01, 16'h5A01, 16'h5B00, 16'h5A00}, "R7 excess dropped");
    beat(4'b0001, 16'h5A00, 16'h0, 16'h0, 16'h0);
    beat(4'b0001, 16'h5A01, 16'h0, 16'h0, 16'h0);
    beat(4'b0001, 16'hEEEE, 16'h0, 16'h0, 16'h0);
    beat(4'b0010, 16'h0, 16'h5B00, 16'h0, 16'h0);
    beat(4'b0011, 16'hFFFF, 16'h5B01, 16'h0, 16'h0);
    idle(2);

    // R8: three-bit mask acts as four
    set_mask(4'b0111);
    expect_word({16'h8003, 16'h8002, 16'h8001, 16'h8000}, "R8 three as four");
    beat(4'b0111, 16'h8000, 16'h8001, 16'h8002, 16'h0);
    idle(1);
    chk(out_valid_o == 1'b0, "R8 word needs ch3", WW'(out_valid_o), '0);
    beat(4'b1000, 16'h0, 16'h0, 16'h0, 16'h8003);
    idle(2);

    // R9: mask change drops partial fill and samples of that cycle
    set_mask(4'b0001);
    beat(4'b0001, 16'h9990, 16'h0, 16'h0, 16'h0);
    beat(4'b0001, 16'h9991, 16'h0, 16'h0, 16'h0);
    ch_en_i = 4'b0011;
    beat(4'b0011, 16'h7777, 16'h7777, 16'h0, 16'h0);
    chk(out_valid_o == 1'b0, "R9 no word on change", WW'(out_valid_o), '0);
    expect_word({16'h9B01, 16'h9A01, 16'h9B00, 16'h9A00}, "R9 fresh word");
    beat(4'b0011, 16'h9A00, 16'h9B00, 16'h0, 16'h0);
    beat(4'b0011, 16'h9A01, 16'h9B01, 16'h0, 16'h0);
    idle(2);

    // R10 / R11: stall, overflow and hold
    set_mask(4'b1111);
    out_ready_i = 1'b0;
    expect_word({16'hD003, 16'hD002, 16'hD001, 16'hD000}, "R11 held word");
    beat(4'b1111, 16'hD000, 16'hD001, 16'hD002, 16'hD003);
    chk(ovf_o == 1'b0, "R10 no ovf on first", WW'(ovf_o), '0);
    beat(4'b1111, 16'hE000, 16'hE001, 16'hE002, 16'hE003);
    chk(ovf_o == 1'b1, "R10 ovf pulse", WW'(ovf_o), WW'(1));
    chk(out_data_o == {16'hD003, 16'hD002, 16'hD001, 16'hD000}, "R11 data held",
        out_data_o, {16'hD003, 16'hD002, 16'hD001, 16'hD000});
    idle(1);
    chk(ovf_o == 1'b0, "R10 ovf one cycle", WW'(ovf_o), '0);
    out_ready_i = 1'b1;
    idle(3);
    chk(out_valid_o == 1'b0, "R11 drained", WW'(out_valid_o), '0);

    chk(exp_q.size() == 0, "R11 all words seen", WW'(exp_q.size()), '0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule